// File: doc/BRIEF.md
# Sleep Depth and Wake-Up Controller

This block decides when the clocks of a small embedded controller CPU run. It supports two sleep depths. A decoded HALT strobe from the core starts a light sleep. In light sleep only the core/ALU clock is gated, and the timer and interrupt logic keep their clock. A decoded STOP strobe starts a deep sleep. In deep sleep the core clock, the timer clock and the oscillator driver are all switched off. The block runs on a free-running controller clock and is reset by an asynchronous active-low reset.

Two events end either sleep: a CPU reset request, or a host write into the input data buffer. Leaving deep sleep goes through an oscillator-settle state. In that state the oscillator driver is on, but the clocks stay gated until the synchronized oscillator-stable input is high and no CPU reset is being held. When the block returns to run, it gives the core a one-cycle resume directive:
- carry on at the next instruction;
- call the interrupt vector, after a host write while the input-buffer-full interrupt is enabled;
- restart at program address 0, after a reset.

Top module: `pdm_ctrl`

## Requirements
- R1: While rst_n is low and in the first cycle after it is released, the block is in run: core_clk_en_o, tmr_clk_en_o and osc_en_o are 1 and resume_vld_o is 0.
- R2: In run with cpu_rst_i low, a halt_i pulse gates the core from the next cycle on: core_clk_en_o=0, tmr_clk_en_o=1, osc_en_o=1.
- R3: In run with cpu_rst_i low, a stop_i pulse turns all three enables off from the next cycle on. If stop_i and halt_i arrive together, stop_i wins.
- R4: In light sleep, a host_wr_i pulse without cpu_rst_i returns the block to run in the next cycle. resume_o is 1 (call interrupt) when ibf_ie_i is 1, and 0 (next instruction) otherwise.
- R5: In light sleep, cpu_rst_i returns the block to run in the next cycle with resume_o=2 (restart at address 0).
- R6: When cpu_rst_i and host_wr_i are both high in a wake cycle, or while the block waits for the oscillator, the reset wins and the final resume_o is 2.
- R7: In deep sleep, a wake event moves the block to oscillator settle: osc_en_o=1, core_clk_en_o=0, tmr_clk_en_o=0. This holds until osc_stable_i has passed the SYNC_STAGES-flop synchronizer. Run starts one cycle after that, which is SYNC_STAGES+1 cycles after osc_stable_i rises.
- R8: A deep-sleep wake caused by reset keeps the clocks gated while cpu_rst_i stays high, even when the oscillator is stable. Run starts in the cycle after cpu_rst_i falls, with resume_o=2.
- R9: halt_i and stop_i have no effect while the block is in either sleep depth.
- R10: resume_vld_o is high for exactly one cycle, and only in the first cycle back in run.
- R11: halt_i or stop_i that arrives while cpu_rst_i is high leaves the block in run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| halt_i | input | 1 | Decoded HALT instruction strobe |
| stop_i | input | 1 | Decoded STOP instruction strobe |
| cpu_rst_i | input | 1 | CPU reset request (active high) |
| host_wr_i | input | 1 | Host wrote a byte into the input data buffer |
| ibf_ie_i | input | 1 | Input-buffer-full interrupt enable |
| osc_stable_i | input | 1 | Oscillator stable indication (asynchronous) |
| core_clk_en_o | output | 1 | Core/ALU clock enable |
| tmr_clk_en_o | output | 1 | Timer and interrupt clock enable |
| osc_en_o | output | 1 | Oscillator driver enable |
| resume_vld_o | output | 1 | One-cycle resume directive strobe |
| resume_o | output | 2 | Resume directive: 0 next, 1 call interrupt, 2 restart |

## Verification
A CPU reset request and a host write can arrive in the same cycle as wake events. They can also meet while the block waits for the oscillator. The bench drives both in one cycle in light sleep, and drives both again in the settle state after a host-write wake. In each case it checks that the single resume strobe carries the restart code and never the call or next code. It also raises a reset request in the same cycle as a halt strobe in run, and checks that the core clock stays enabled.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_SOFT = 2'd1,
    ST_HARD = 2'd2,
    ST_OSCW = 2'd3
  } pdm_state_e;

  localparam int RESUME_W = 2;

  typedef enum logic [RESUME_W-1:0] {
    RES_NEXT    = 2'd0,
    RES_CALL    = 2'd1,
    RES_RESTART = 2'd2
  } pdm_resume_e;
endpackage

// File: rtl/pdm_sync.sv
module pdm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pdm_wake_arb.sv
module pdm_wake_arb
  import pdm_pkg::*;
(
  input  logic        cpu_rst_i,
  input  logic        host_wr_i,
  input  logic        ibf_ie_i,
  output logic        wake_o,
  output pdm_resume_e cause_o
);
  // Reset has priority over a host write arriving in the same cycle.
  always_comb begin
    wake_o  = cpu_rst_i | host_wr_i;
    if (cpu_rst_i)     cause_o = RES_RESTART;
    else if (ibf_ie_i) cause_o = RES_CALL;
    else               cause_o = RES_NEXT;
  end
endmodule

// File: rtl/pdm_gate_dec.sv
module pdm_gate_dec
  import pdm_pkg::*;
(
  input  pdm_state_e state_i,
  output logic       core_en_o,
  output logic       tmr_en_o,
  output logic       osc_en_o
);
  always_comb begin
    core_en_o = 1'b0;
    tmr_en_o  = 1'b0;
    osc_en_o  = 1'b0;
    unique case (state_i)
      ST_RUN:  begin core_en_o = 1'b1; tmr_en_o = 1'b1; osc_en_o = 1'b1; end
      ST_SOFT: begin tmr_en_o  = 1'b1; osc_en_o = 1'b1; end
      ST_HARD: ;
      ST_OSCW: osc_en_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/pdm_fsm.sv
module pdm_fsm
  import pdm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        halt_i,
  input  logic        stop_i,
  input  logic        cpu_rst_i,
  input  logic        wake_i,
  input  pdm_resume_e cause_i,
  input  logic        osc_sync_i,
  output pdm_state_e  state_o,
  output logic        resume_vld_o,
  output pdm_resume_e resume_o
);
  pdm_state_e  state_q, state_d;
  pdm_resume_e cause_q, cause_d;
  pdm_resume_e code_q, code_d;
  logic        vld_q, vld_d;
  logic        cause_en, code_en;

  always_comb begin
    state_d  = state_q;
    cause_d  = cause_q;
    code_d   = code_q;
    vld_d    = 1'b0;
    cause_en = 1'b0;
    code_en  = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (!cpu_rst_i) begin
          if (stop_i)      state_d = ST_HARD;
          else if (halt_i) state_d = ST_SOFT;
        end
      end
      ST_SOFT: begin
        if (wake_i) begin
          state_d = ST_RUN;
          vld_d   = 1'b1;
          code_d  = cause_i;
          code_en = 1'b1;
        end
      end
      ST_HARD: begin
        if (wake_i) begin
          state_d  = ST_OSCW;
          cause_d  = cause_i;
          cause_en = 1'b1;
        end
      end
      ST_OSCW: begin
        if (cpu_rst_i) begin
          cause_d  = RES_RESTART;
          cause_en = 1'b1;
        end else if (osc_sync_i) begin
          state_d = ST_RUN;
          vld_d   = 1'b1;
          code_d  = cause_q;
          code_en = 1'b1;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      vld_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      vld_q   <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause_q <= RES_NEXT;
    else if (cause_en) cause_q <= cause_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= RES_NEXT;
    else if (code_en) code_q <= code_d;
  end

  assign state_o      = state_q;
  assign resume_vld_o = vld_q;
  assign resume_o     = code_q;
endmodule

// File: rtl/pdm_ctrl.sv
module pdm_ctrl
  import pdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                halt_i,
  input  logic                stop_i,
  input  logic                cpu_rst_i,
  input  logic                host_wr_i,
  input  logic                ibf_ie_i,
  input  logic                osc_stable_i,
  output logic                core_clk_en_o,
  output logic                tmr_clk_en_o,
  output logic                osc_en_o,
  output logic                resume_vld_o,
  output logic [RESUME_W-1:0] resume_o
);
  pdm_state_e  state_w;
  pdm_resume_e cause_w;
  pdm_resume_e code_w;
  logic        wake_w;
  logic        osc_sync_w;

  pdm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (osc_stable_i),
    .q_o   (osc_sync_w)
  );

  pdm_wake_arb u_arb (
    .cpu_rst_i (cpu_rst_i),
    .host_wr_i (host_wr_i),
    .ibf_ie_i  (ibf_ie_i),
    .wake_o    (wake_w),
    .cause_o   (cause_w)
  );

  pdm_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .halt_i       (halt_i),
    .stop_i       (stop_i),
    .cpu_rst_i    (cpu_rst_i),
    .wake_i       (wake_w),
    .cause_i      (cause_w),
    .osc_sync_i   (osc_sync_w),
    .state_o      (state_w),
    .resume_vld_o (resume_vld_o),
    .resume_o     (code_w)
  );

  pdm_gate_dec u_dec (
    .state_i   (state_w),
    .core_en_o (core_clk_en_o),
    .tmr_en_o  (tmr_clk_en_o),
    .osc_en_o  (osc_en_o)
  );

  assign resume_o = code_w;
endmodule

// File: rtl/pdm_ctrl_chk.sv
module pdm_ctrl_chk
  import pdm_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       halt_i,
  input logic       stop_i,
  input logic       cpu_rst_i,
  input logic       host_wr_i,
  input logic       core_clk_en_o,
  input logic       tmr_clk_en_o,
  input logic       osc_en_o,
  input logic       resume_vld_o,
  input logic [1:0] resume_o,
  input pdm_state_e state_w,
  input logic       osc_sync_w
);
  p_halt_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_w == ST_RUN && halt_i && !stop_i && !cpu_rst_i) |=> (!core_clk_en_o && tmr_clk_en_o && osc_en_o));

  p_stop_enter_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_w == ST_RUN && stop_i && !cpu_rst_i) |=> (!core_clk_en_o && !tmr_clk_en_o && !osc_en_o));

  p_soft_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_w == ST_SOFT && cpu_rst_i) |=> (resume_vld_o && resume_o == 2'd2));

  p_settle_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_w == ST_OSCW && !osc_sync_w) |=> (!core_clk_en_o && osc_en_o));

  p_reset_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_w == ST_OSCW && cpu_rst_i) |=> !core_clk_en_o);

  p_soft_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_w == ST_SOFT && !cpu_rst_i && !host_wr_i) |=> (!core_clk_en_o && tmr_clk_en_o));

  p_pulse_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resume_vld_o |=> !resume_vld_o);

  p_pulse_in_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resume_vld_o |-> core_clk_en_o);

  p_reset_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_w == ST_RUN && cpu_rst_i) |=> core_clk_en_o);
endmodule

bind pdm_ctrl pdm_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .halt_i        (halt_i),
  .stop_i        (stop_i),
  .cpu_rst_i     (cpu_rst_i),
  .host_wr_i     (host_wr_i),
  .core_clk_en_o (core_clk_en_o),
  .tmr_clk_en_o  (tmr_clk_en_o),
  .osc_en_o      (osc_en_o),
  .resume_vld_o  (resume_vld_o),
  .resume_o      (resume_o),
  .state_w       (state_w),
  .osc_sync_w    (osc_sync_w)
);

// File: tb/pdm_ctrl_tb.sv
module pdm_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic halt_i, stop_i, cpu_rst_i, host_wr_i, ibf_ie_i, osc_stable_i;
  logic core_clk_en_o, tmr_clk_en_o, osc_en_o, resume_vld_o;
  logic [1:0] resume_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdm_ctrl #(.SYNC_STAGES(SYNC)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .halt_i        (halt_i),
    .stop_i        (stop_i),
    .cpu_rst_i     (cpu_rst_i),
    .host_wr_i     (host_wr_i),
    .ibf_ie_i      (ibf_ie_i),
    .osc_stable_i  (osc_stable_i),
    .core_clk_en_o (core_clk_en_o),
    .tmr_clk_en_o  (tmr_clk_en_o),
    .osc_en_o      (osc_en_o),
    .resume_vld_o  (resume_vld_o),
    .resume_o      (resume_o)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Enables packed as {core, tmr, osc}
  function automatic logic [3:0] ens();
    return {1'b0, core_clk_en_o, tmr_clk_en_o, osc_en_o};
  endfunction

  task automatic pulse_halt(); halt_i = 1'b1; tick(); halt_i = 1'b0; endtask
  task automatic pulse_stop(); stop_i = 1'b1; osc_stable_i = 1'b0; tick(); stop_i = 1'b0; endtask
  task automatic pulse_host(input logic ie);
    ibf_ie_i = ie; host_wr_i = 1'b1; tick(); host_wr_i = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) tick();
    chk("R1 enables in reset", ens(), 4'h7);
    chk("R1 no resume in reset", {3'b0, resume_vld_o}, 4'h0);
    rst_n = 1'b1;
    tick();
    chk("R1 enables after reset", ens(), 4'h7);
    chk("R1 no resume after reset", {3'b0, resume_vld_o}, 4'h0);
  endtask

  task automatic t_soft_host();
    pulse_halt();
    chk("R2 light sleep gating", ens(), 4'h3);
    pulse_host(1'b1);
    chk("R4 back to run", ens(), 4'h7);
    chk("R4 call strobe", {3'b0, resume_vld_o}, 4'h1);
    chk("R4 call code", {2'b0, resume_o}, 4'h1);
    tick();
    chk("R10 strobe one cycle", {3'b0, resume_vld_o}, 4'h0);
    pulse_halt();
    pulse_host(1'b0);
    chk("R4 next code strobe", {3'b0, resume_vld_o}, 4'h1);
    chk("R4 next code", {2'b0, resume_o}, 4'h0);
    tick();
  endtask

  task automatic t_soft_reset();
    pulse_halt();
    cpu_rst_i = 1'b1; tick(); cpu_rst_i = 1'b0;
    chk("R5 run after reset wake", ens(), 4'h7);
    chk("R5 restart code", {1'b0, resume_vld_o, resume_o}, 4'h6);
    tick();
  endtask

  task automatic t_soft_collision();
    pulse_halt();
    cpu_rst_i = 1'b1; host_wr_i = 1'b1; ibf_ie_i = 1'b1;
    tick();
    cpu_rst_i = 1'b0; host_wr_i = 1'b0;
    chk("R6 reset beats host write", {1'b0, resume_vld_o, resume_o}, 4'h6);
    tick();
  endtask

  task automatic t_stop_over_halt();
    halt_i = 1'b1; stop_i = 1'b1; osc_stable_i = 1'b0;
    tick();
    halt_i = 1'b0; stop_i = 1'b0;
    chk("R3 stop wins over halt", ens(), 4'h0);
  endtask

  task automatic t_hard_host();
    pulse_stop();
    chk("R3 deep sleep gating", ens(), 4'h0);
    pulse_host(1'b1);
    chk("R7 settle enables", ens(), 4'h1);
    osc_stable_i = 1'b1;
    for (int i = 0; i < SYNC; i++) begin
      tick();
      chk("R7 gated while syncing", ens(), 4'h1);
    end
    tick();
    chk("R7 run after settle", ens(), 4'h7);
    chk("R7 call code after settle", {1'b0, resume_vld_o, resume_o}, 4'h5);
    tick();
    chk("R10 strobe drops", {3'b0, resume_vld_o}, 4'h0);
  endtask

  task automatic t_hard_reset();
    pulse_stop();
    cpu_rst_i = 1'b1;
    tick();
    chk("R8 settle on reset wake", ens(), 4'h1);
    osc_stable_i = 1'b1;
    repeat (SYNC + 3) tick();
    chk("R8 held by reset", ens(), 4'h1);
    chk("R8 no strobe while held", {3'b0, resume_vld_o}, 4'h0);
    cpu_rst_i = 1'b0;
    tick();
    chk("R8 run after reset release", ens(), 4'h7);
    chk("R8 restart code", {1'b0, resume_vld_o, resume_o}, 4'h6);
    tick();
  endtask

  task automatic t_hard_collision();
    pulse_stop();
    pulse_host(1'b1);
    cpu_rst_i = 1'b1; osc_stable_i = 1'b1;
    repeat (SYNC + 1) tick();
    cpu_rst_i = 1'b0;
    tick();
    chk("R6 reset during settle wins", {1'b0, resume_vld_o, resume_o}, 4'h6);
    tick();
  endtask

  task automatic t_ignore();
    pulse_halt();
    pulse_stop();
    chk("R9 stop ignored in light sleep", ens(), 4'h3);
    pulse_host(1'b0);
    tick();
    pulse_stop();
    pulse_halt();
    chk("R9 halt ignored in deep sleep", ens(), 4'h0);
    pulse_host(1'b0);
    osc_stable_i = 1'b1;
    repeat (SYNC + 1) tick();
    chk("R9 clean exit", ens(), 4'h7);
    tick();
  endtask

  task automatic t_run_reset_blocks();
    cpu_rst_i = 1'b1; halt_i = 1'b1;
    tick();
    halt_i = 1'b0; stop_i = 1'b1;
    tick();
    stop_i = 1'b0; cpu_rst_i = 1'b0;
    chk("R11 strobes blocked by reset", ens(), 4'h7);
    chk("R11 no strobe", {3'b0, resume_vld_o}, 4'h0);
  endtask

  initial begin
    halt_i = 0; stop_i = 0; cpu_rst_i = 0; host_wr_i = 0; ibf_ie_i = 0; osc_stable_i = 1;
    rst_n = 0;
    #1;
    t_reset();
    t_soft_host();
    t_soft_reset();
    t_soft_collision();
    t_stop_over_halt();
    osc_stable_i = 1'b1;
    pulse_host(1'b0);
    repeat (SYNC + 2) tick();
    t_hard_host();
    t_hard_reset();
    t_hard_collision();
    t_ignore();
    t_run_reset_blocks();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule